// File: doc/BRIEF.md
# Thermal Clock Modulation Duty Controller

This block cuts core power by switching a clock-enable strobe on and off in a repeating pattern. The core clock is never divided; it is allowed to run during some time slots and stopped during the rest. A free-running counter splits time into periods of eight equal slots. A duty value n enables the clock for the first n slots of each period and blocks it for the other 8−n. The possible duties run from one eighth on up to seven eighths on, in steps of one eighth.

Two sources can ask for modulation. Software can turn on an on-demand mode and write a 3-bit duty code into bits 3:1 of a control register. A thermal-trip input signals that the die has reached its maximum operating temperature; it applies a fixed duty that is set when the block is built. When both sources are active, the thermal duty always wins. A 2-bit status output shows which source picked the duty now in force. The block only switches duty or source at a period boundary, so it never produces a shortened enable pulse.

Top module: `thermal_duty_gate`

## Requirements
- R1: While reset is asserted, and for the whole first period after reset is released, `clk_en_o` is 1 and `src_o` is 2'b00.
- R2: A period is 8 slots of `SLOT_CYCLES` clock cycles each. Slots are numbered 0 to 7 from the start of the period. With active duty n (1..7), `clk_en_o` is 1 in slots 0..n−1 and 0 in slots n..7.
- R3: If `trip_i` is low, `dmd_en_i` is high and the code in `ctl_reg_i[3:1]` is 1..7, the duty equals that code and `src_o` is 2'b01.
- R4: If `trip_i` is high, the duty is `THERM_DUTY` and `src_o` is 2'b10, whatever the on-demand enable and code are.
- R5: If `trip_i` is low, `dmd_en_i` is high and the code is 0, the code counts as reserved: `clk_en_o` stays 1 for the whole period and `src_o` is 2'b00.
- R6: If `trip_i` and `dmd_en_i` are both low, `clk_en_o` stays 1 for the whole period and `src_o` is 2'b00.
- R7: The inputs are sampled only on the last cycle of a period and take effect from slot 0 of the next period. A change in the middle of a period has no effect on that period.
- R8: Bit 0 and bits above 3 of `ctl_reg_i` have no effect on `clk_en_o` or `src_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the only clock domain |
| rst_n | input | 1 | Synchronous reset, active low |
| trip_i | input | 1 | Thermal trip: maximum operating temperature reached |
| dmd_en_i | input | 1 | On-demand modulation enable |
| ctl_reg_i | input | CTL_W | Control register value; bits 3:1 hold the on-demand duty code |
| clk_en_o | output | 1 | Clock-enable strobe for the gating cell |
| src_o | output | 2 | Source of the duty in force: 00 none, 01 on-demand, 10 thermal |

## Verification
The assertions assume the control inputs are stable, synchronous levels sampled at the clock edge. They also assume the only moment that matters is the final cycle of a period, so they relate boundary-cycle inputs to the state one cycle later and check that nothing moves between boundaries. The stimulus drives inputs only on falling clock edges. It sweeps every combination of trip, on-demand enable and the eight codes, one period each. It adds changes in the middle of a period and random values in the bits outside the code field, so the bench can check that only the boundary-cycle values matter.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
   localparam int unsigned SLOTS  = 8;
   localparam int unsigned DUTY_W = 3;

   typedef enum logic [1:0] {
      SRC_NONE   = 2'b00,
      SRC_DEMAND = 2'b01,
      SRC_THERM  = 2'b10
   } duty_src_e;

   typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/tdg_period_cnt.sv
module tdg_period_cnt #(
   parameter int unsigned SLOT_CYCLES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   output logic [tdg_pkg::DUTY_W-1:0] slot_o,
   output logic                       last_o
);
   import tdg_pkg::*;

   localparam int unsigned CYC_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

   logic        step;
   duty_t       slot_q;

   generate
      if (SLOT_CYCLES == 1) begin : g_single
         assign step = 1'b1;
      end else begin : g_multi
         logic [CYC_W-1:0] cyc_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                               cyc_q <= '0;
            else if (cyc_q == CYC_W'(SLOT_CYCLES-1))  cyc_q <= '0;
            else                                      cyc_q <= cyc_q + 1'b1;
         end
         assign step = (cyc_q == CYC_W'(SLOT_CYCLES-1));

         // R2: slot counter wraps before overrunning the slot length
         p_cyc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cyc_q <= CYC_W'(SLOT_CYCLES-1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    slot_q <= '0;
      else if (step) slot_q <= slot_q + 1'b1;
   end

   assign slot_o = slot_q;
   assign last_o = step && (slot_q == duty_t'(SLOTS-1));

   // R2: the slot index only moves at the end of a slot
   p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(slot_q));
   p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (slot_q == duty_t'($past(slot_q) + 1'b1)));
endmodule

// File: rtl/tdg_src_select.sv
module tdg_src_select #(
   parameter int unsigned THERM_DUTY = 4
) (
   input  logic                       trip_i,
   input  logic                       dmd_en_i,
   input  logic [tdg_pkg::DUTY_W-1:0] code_i,
   output logic [tdg_pkg::DUTY_W-1:0] duty_o,
   output tdg_pkg::duty_src_e         src_o
);
   import tdg_pkg::*;

   // duty value 0 means "no modulation, clock always enabled"
   always_comb begin
      if (trip_i) begin
         duty_o = duty_t'(THERM_DUTY);
         src_o  = SRC_THERM;
      end else if (dmd_en_i && (code_i != '0)) begin
         duty_o = code_i;
         src_o  = SRC_DEMAND;
      end else begin
         duty_o = '0;
         src_o  = SRC_NONE;
      end
   end
endmodule

// File: rtl/tdg_pattern.sv
module tdg_pattern (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load_i,
   input  logic [tdg_pkg::DUTY_W-1:0] duty_i,
   input  tdg_pkg::duty_src_e         src_i,
   input  logic [tdg_pkg::DUTY_W-1:0] slot_i,
   output logic                       en_o,
   output tdg_pkg::duty_src_e         src_o
);
   import tdg_pkg::*;

   duty_t     act_duty;
   duty_src_e act_src;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_duty <= '0;
         act_src  <= SRC_NONE;
      end else if (load_i) begin
         act_duty <= duty_i;
         act_src  <= src_i;
      end
   end

   assign en_o  = (act_duty == '0) || (slot_i < act_duty);
   assign src_o = act_src;

   // R7: the active setting is frozen between period boundaries
   p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(act_duty) && $stable(act_src)));
   // R6: with no source in force the clock is never blocked
   p_none_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_src == SRC_NONE) |-> en_o);
   // R2: each period opens with an enabled slot
   p_slot0_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_i == '0) |-> en_o);
endmodule

// File: rtl/thermal_duty_gate.sv
module thermal_duty_gate #(
   parameter int unsigned CTL_W       = 8,
   parameter int unsigned SLOT_CYCLES = 4,
   parameter int unsigned THERM_DUTY  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trip_i,
   input  logic             dmd_en_i,
   input  logic [CTL_W-1:0] ctl_reg_i,
   output logic             clk_en_o,
   output logic [1:0]       src_o
);
   import tdg_pkg::*;

   localparam int unsigned CODE_LSB = 1;

   generate
      if (CTL_W < CODE_LSB + DUTY_W) begin : g_bad_ctl_w
         $error("CTL_W too small to hold the duty code field");
      end
      if (SLOT_CYCLES < 1) begin : g_bad_slot
         $error("SLOT_CYCLES must be at least 1");
      end
      if (THERM_DUTY < 1 || THERM_DUTY > SLOTS-1) begin : g_bad_therm
         $error("THERM_DUTY must be in 1..7");
      end
   endgenerate

   duty_t     code;
   duty_t     slot;
   logic      boundary;
   duty_t     sel_duty;
   duty_src_e sel_src;
   duty_src_e act_src;

   assign code = ctl_reg_i[CODE_LSB +: DUTY_W];

   tdg_period_cnt #(.SLOT_CYCLES(SLOT_CYCLES)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .slot_o (slot),
      .last_o (boundary)
   );

   tdg_src_select #(.THERM_DUTY(THERM_DUTY)) u_sel (
      .trip_i   (trip_i),
      .dmd_en_i (dmd_en_i),
      .code_i   (code),
      .duty_o   (sel_duty),
      .src_o    (sel_src)
   );

   tdg_pattern u_pat (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (boundary),
      .duty_i (sel_duty),
      .src_i  (sel_src),
      .slot_i (slot),
      .en_o   (clk_en_o),
      .src_o  (act_src)
   );

   assign src_o = act_src;

   // R4: a trip on the boundary cycle always selects the thermal source
   p_therm_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && trip_i) |=> (src_o == SRC_THERM));
   // R3: on-demand with a non-zero code is reported as on-demand
   p_demand_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !trip_i && dmd_en_i && (code != '0)) |=> (src_o == SRC_DEMAND));
   // R5: reserved code leaves the clock running
   p_reserved_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !trip_i && dmd_en_i && (code == '0)) |=> (clk_en_o && src_o == SRC_NONE));
   // R6: no source active leaves the clock running
   p_idle_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !trip_i && !dmd_en_i) |=> (clk_en_o && src_o == SRC_NONE));
endmodule

// File: tb/sim_thermal_duty_gate.sv
module sim_thermal_duty_gate;
   localparam int CTL_W  = 8;
   localparam int SLOTC  = 4;
   localparam int TDUTY  = 4;
   localparam int PER    = 8 * SLOTC;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             trip_i = 1'b0;
   logic             dmd_en_i = 1'b0;
   logic [CTL_W-1:0] ctl_reg_i = '0;
   logic             clk_en_o;
   logic [1:0]       src_o;

   int n_chk = 0;
   int n_bad = 0;
   int exp_duty = 0;   // 0 = full on
   int exp_src  = 0;

   always #5 clk = ~clk;

   thermal_duty_gate #(.CTL_W(CTL_W), .SLOT_CYCLES(SLOTC), .THERM_DUTY(TDUTY)) u0 (
      .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .dmd_en_i(dmd_en_i),
      .ctl_reg_i(ctl_reg_i), .clk_en_o(clk_en_o), .src_o(src_o)
   );

   task automatic check(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
      end
   endtask

   task automatic drive(input bit tr, input bit od, input int code, input int junk);
      trip_i    = tr;
      dmd_en_i  = od;
      ctl_reg_i = CTL_W'(((junk & 8'hF1)) | ((code & 7) << 1));
   endtask

   // expected outcome computed from R3..R6
   task automatic predict(input bit tr, input bit od, input int code);
      if (tr)                   begin exp_duty = TDUTY; exp_src = 2; end
      else if (od && code != 0) begin exp_duty = code;  exp_src = 1; end
      else                      begin exp_duty = 0;     exp_src = 0; end
   endtask

   // called at a falling edge on slot 0 of a period
   task automatic run_period(input string req, input bit tr, input bit od, input int code,
                             input int junk, input bit mid, input bit tr2, input bit od2,
                             input int code2, input int junk2);
      drive(tr, od, code, junk);
      for (int i = 0; i < PER; i++) begin
         int slot;
         int en;
         slot = i / SLOTC;
         en = (exp_duty == 0 || slot < exp_duty) ? 1 : 0;
         check(req, int'(clk_en_o), en);
         if (i == 0) check(req, int'(src_o), exp_src);
         if (mid && i == 10) drive(tr2, od2, code2, junk2);
         @(negedge clk);
      end
      if (mid) predict(tr2, od2, code2);
      else     predict(tr, od, code);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      drive(1'b1, 1'b1, 3, 8'hFF);
      repeat (3) @(negedge clk);
      check("R1", int'(clk_en_o), 1);
      check("R1", int'(src_o), 0);
      rst_n = 1'b1;
      // first period after reset: full on, no source (R1)
      exp_duty = 0; exp_src = 0;
      run_period("R1", 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0);

      // sweep: trip x demand enable x code, with other ctl bits varied (R2..R6, R8)
      for (int tr = 0; tr < 2; tr++)
         for (int od = 0; od < 2; od++)
            for (int c = 0; c < 8; c++) begin
               string r;
               if (tr != 0)           r = "R4";
               else if (od == 0)      r = "R6";
               else if (c == 0)       r = "R5";
               else                   r = "R3/R2";
               run_period(r, bit'(tr), bit'(od), c, (c * 53 + tr * 17 + od * 5) & 8'hF1,
                          1'b0, 1'b0, 1'b0, 0, 0);
            end

      // ignored bits only toggling, same code (R8)
      run_period("R8", 1'b0, 1'b1, 5, 8'h00, 1'b1, 1'b0, 1'b1, 5, 8'hF1);
      run_period("R8", 1'b0, 1'b1, 5, 8'hF1, 1'b0, 1'b0, 1'b0, 0, 0);
      // mid-period changes must wait for the boundary (R7)
      run_period("R7", 1'b0, 1'b1, 2, 0, 1'b1, 1'b0, 1'b1, 6, 0);
      run_period("R7", 1'b0, 1'b1, 6, 0, 1'b1, 1'b1, 1'b1, 6, 0);
      run_period("R7", 1'b1, 1'b0, 0, 0, 1'b1, 1'b0, 1'b0, 0, 0);
      run_period("R7", 1'b0, 1'b1, 7, 0, 1'b1, 1'b0, 1'b1, 1, 0);
      run_period("R2", 1'b0, 1'b1, 1, 0, 1'b0, 1'b0, 1'b0, 0, 0);
      run_period("R6", 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule